// File: doc/BRIEF.md
# AXI4-Lite Register Front End with Error Responses

This block sits between an AXI4-Lite manager and a simple local register bus. It takes a write address and write data on separate channels, in either order or together, and issues a single local write once both are held. It takes a read address, issues a local read, and waits for the backend to return data. Every transaction ends with exactly one response, and that response carries an error code when the access cannot be served.

An access is checked against a per-register attribute table given as parameters: how many registers are mapped, which may be read and which may be written. An access to an unmapped register, an access in the wrong direction, or a local access that the backend does not finish within a set number of cycles each gets an error response instead of OKAY. Only the low address bits selected by a parameter take part in the decode. The block therefore still works when an interconnect has placed it at a non-zero base address.

All AXI channels follow the valid/ready rules. A source holds its valid and payload stable until ready is seen. BVALID and RVALID, with their payloads, stay up until the manager raises BREADY or RREADY. No new transaction in a direction is accepted while that direction's response is still waiting. The local bus uses a request held high until the backend answers: the backend raises `lb_wready` or `lb_rvalid` in the cycle it completes.

Top module: `axil_err_slave`

## Requirements
- R1: After a synchronous active-low reset, `awready`, `wready` and `arready` are 1, and `bvalid`, `rvalid`, `lb_wreq` and `lb_rreq` are 0.
- R2: Write address and write data are accepted independently, in either order or in the same cycle. Once both are held, exactly one local write is issued, with the received data and with `wstrb` passed unchanged to `lb_wstrb`.
- R3: `lb_wreq` stays high, with its address, data and strobes stable, until the cycle in which `lb_wready` is 1. A write completed this way returns BRESP OKAY (2'b00).
- R4: `lb_rreq` stays high, with its address stable, until the cycle in which `lb_rvalid` is 1. The `lb_rdata` of that cycle is returned on RDATA with RRESP OKAY (2'b00).
- R5: Register i sits at byte offset 4*i, and address bits [1:0] are ignored. An access whose word index is NUM_REGS or more returns DECERR (2'b11), issues no local request, and a read returns RDATA zero.
- R6: A write to a register whose WR_OK bit is 0, or a read of a register whose RD_OK bit is 0, returns SLVERR (2'b10) and issues no local request. With the defaults, register 6 is read-only and register 7 is write-only; a rejected read returns RDATA zero.
- R7: A local request that sees no `lb_wready` or `lb_rvalid` in any of its first TIMEOUT cycles is dropped after exactly TIMEOUT cycles. The transaction then returns SLVERR (2'b10), and a read returns RDATA zero. A completion in cycle TIMEOUT itself still returns OKAY.
- R8: Address bits at and above REG_ADDR_W have no effect. The local address is the word-aligned low REG_ADDR_W bits.
- R9: While BVALID or RVALID is high and its ready is low, the valid stays high and the response code and data stay stable. Only one write and one read are outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | AXI_ADDR_W | Write address |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte strobes |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | AXI_ADDR_W | Read address |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code |
| lb_wreq | output | 1 | Local write request, held until `lb_wready` |
| lb_wready | input | 1 | Local write completion |
| lb_waddr | output | REG_ADDR_W | Local write byte address, word aligned |
| lb_wdata | output | DATA_W | Local write data |
| lb_wstrb | output | DATA_W/8 | Local write strobes |
| lb_rreq | output | 1 | Local read request, held until `lb_rvalid` |
| lb_rvalid | input | 1 | Local read completion |
| lb_raddr | output | REG_ADDR_W | Local read byte address, word aligned |
| lb_rdata | input | DATA_W | Local read data |

## Verification
Writes are driven with address and data arriving together, address first and data first. A mismatch between these orderings shows a channel-joining fault, where one order drops or duplicates the local write. Random addresses combine random upper bits, random low bits and word indices on both sides of the mapped range. These tell the decode faults apart: unmapped versus wrong-direction accesses, and upper-bit leakage. Backend latencies are swept from zero to past the timeout, with directed cases at exactly TIMEOUT-1 and TIMEOUT. This pins the timeout boundary to the cycle and also counts how many request cycles the backend saw. Random delays on BREADY and RREADY test that responses are held while the manager stalls.

// File: rtl/axil_err_pkg.sv
package axil_err_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;
endpackage

// File: rtl/axil_err_decode.sv
// Attribute lookup for one access direction: mapped, allowed or rejected.
module axil_err_decode
  import axil_err_pkg::*;
#(
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned NUM_REGS = 8,
  parameter logic [NUM_REGS-1:0] ALLOW = '1
) (
  input  logic [IDX_W-1:0] idx,
  output resp_e            verdict
);
  logic [NUM_REGS-1:0] hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign hit[i] = (idx == IDX_W'(i));
  end

  always_comb begin
    if (!(|hit))               verdict = RESP_DECERR;
    else if (!(|(hit & ALLOW))) verdict = RESP_SLVERR;
    else                       verdict = RESP_OKAY;
  end
endmodule

// File: rtl/axil_err_timer.sv
// Counts cycles of an unanswered local request; flags the last allowed one.
module axil_err_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
    else          cnt <= '0;
  end

  assign expired = run && (cnt == CNT_W'(LIMIT - 1));

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < CNT_W'(LIMIT)));
endmodule

// File: rtl/axil_err_wr.sv
module axil_err_wr
  import axil_err_pkg::*;
#(
  parameter int unsigned AXI_ADDR_W = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REG_ADDR_W = 8,
  parameter int unsigned NUM_REGS   = 8,
  parameter logic [NUM_REGS-1:0] WR_OK = '1,
  parameter int unsigned TIMEOUT    = 16,
  localparam int unsigned STRB_W    = DATA_W / 8,
  localparam int unsigned IDX_W     = REG_ADDR_W - 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  awvalid,
  output logic                  awready,
  input  logic [AXI_ADDR_W-1:0] awaddr,
  input  logic                  wvalid,
  output logic                  wready,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [STRB_W-1:0]     wstrb,
  output logic                  bvalid,
  input  logic                  bready,
  output logic [1:0]            bresp,
  output logic                  lb_wreq,
  input  logic                  lb_wready,
  output logic [REG_ADDR_W-1:0] lb_waddr,
  output logic [DATA_W-1:0]     lb_wdata,
  output logic [STRB_W-1:0]     lb_wstrb
);
  typedef enum logic [1:0] {W_COLLECT, W_LOCAL, W_RESP} wst_e;
  wst_e              st;
  logic              aw_have, w_have;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;
  resp_e             resp_q, verdict;
  logic              expired;
  logic              unused_addr_bits;

  assign unused_addr_bits = ^{awaddr[AXI_ADDR_W-1:REG_ADDR_W], awaddr[1:0]};

  axil_err_decode #(.IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .ALLOW(WR_OK)) u_dec (
    .idx(idx_q), .verdict(verdict));

  axil_err_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(lb_wreq && !lb_wready), .expired(expired));

  assign awready  = (st == W_COLLECT) && !aw_have;
  assign wready   = (st == W_COLLECT) && !w_have;
  assign bvalid   = (st == W_RESP);
  assign bresp    = resp_q;
  assign lb_wreq  = (st == W_LOCAL);
  assign lb_waddr = {idx_q, 2'b00};
  assign lb_wdata = data_q;
  assign lb_wstrb = strb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= W_COLLECT;
      aw_have <= 1'b0;
      w_have  <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
      strb_q  <= '0;
      resp_q  <= RESP_OKAY;
    end else begin
      case (st)
        W_COLLECT: begin
          if (awvalid && awready) begin
            aw_have <= 1'b1;
            idx_q   <= awaddr[REG_ADDR_W-1:2];
          end
          if (wvalid && wready) begin
            w_have <= 1'b1;
            data_q <= wdata;
            strb_q <= wstrb;
          end
          if (aw_have && w_have) begin
            aw_have <= 1'b0;
            w_have  <= 1'b0;
            if (verdict == RESP_OKAY) st <= W_LOCAL;
            else begin
              resp_q <= verdict;
              st     <= W_RESP;
            end
          end
        end
        W_LOCAL: begin
          if (lb_wready) begin
            resp_q <= RESP_OKAY;
            st     <= W_RESP;
          end else if (expired) begin
            resp_q <= RESP_SLVERR;
            st     <= W_RESP;
          end
        end
        W_RESP: if (bready) st <= W_COLLECT;
        default: st <= W_COLLECT;
      endcase
    end
  end

  p_bresp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid && $stable(bresp));
  p_wreq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lb_wreq && !lb_wready && !expired |=> lb_wreq && $stable(lb_waddr) && $stable(lb_wdata) && $stable(lb_wstrb));
  p_timeout_slverr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !lb_wready |=> bvalid && (bresp == 2'b10));
  p_one_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lb_wreq |-> !bvalid);
endmodule

// File: rtl/axil_err_rd.sv
module axil_err_rd
  import axil_err_pkg::*;
#(
  parameter int unsigned AXI_ADDR_W = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REG_ADDR_W = 8,
  parameter int unsigned NUM_REGS   = 8,
  parameter logic [NUM_REGS-1:0] RD_OK = '1,
  parameter int unsigned TIMEOUT    = 16,
  localparam int unsigned IDX_W     = REG_ADDR_W - 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arvalid,
  output logic                  arready,
  input  logic [AXI_ADDR_W-1:0] araddr,
  output logic                  rvalid,
  input  logic                  rready,
  output logic [DATA_W-1:0]     rdata,
  output logic [1:0]            rresp,
  output logic                  lb_rreq,
  input  logic                  lb_rvalid,
  output logic [REG_ADDR_W-1:0] lb_raddr,
  input  logic [DATA_W-1:0]     lb_rdata
);
  typedef enum logic [1:0] {R_IDLE, R_LOCAL, R_RESP} rst_e;
  rst_e              st;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;
  resp_e             resp_q, verdict;
  logic              expired;
  logic              unused_addr_bits;

  assign unused_addr_bits = ^{araddr[AXI_ADDR_W-1:REG_ADDR_W], araddr[1:0]};

  axil_err_decode #(.IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .ALLOW(RD_OK)) u_dec (
    .idx(araddr[REG_ADDR_W-1:2]), .verdict(verdict));

  axil_err_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(lb_rreq && !lb_rvalid), .expired(expired));

  assign arready  = (st == R_IDLE);
  assign rvalid   = (st == R_RESP);
  assign rdata    = data_q;
  assign rresp    = resp_q;
  assign lb_rreq  = (st == R_LOCAL);
  assign lb_raddr = {idx_q, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= R_IDLE;
      idx_q  <= '0;
      data_q <= '0;
      resp_q <= RESP_OKAY;
    end else begin
      case (st)
        R_IDLE: if (arvalid) begin
          idx_q <= araddr[REG_ADDR_W-1:2];
          if (verdict == RESP_OKAY) st <= R_LOCAL;
          else begin
            resp_q <= verdict;
            data_q <= '0;
            st     <= R_RESP;
          end
        end
        R_LOCAL: begin
          if (lb_rvalid) begin
            data_q <= lb_rdata;
            resp_q <= RESP_OKAY;
            st     <= R_RESP;
          end else if (expired) begin
            data_q <= '0;
            resp_q <= RESP_SLVERR;
            st     <= R_RESP;
          end
        end
        R_RESP: if (rready) st <= R_IDLE;
        default: st <= R_IDLE;
      endcase
    end
  end

  p_rvalid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rresp) && $stable(rdata));
  p_err_data_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && (rresp != 2'b00) |-> (rdata == '0));
  p_rreq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lb_rreq && !lb_rvalid && !expired |=> lb_rreq && $stable(lb_raddr));
  p_rd_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !lb_rvalid |=> rvalid && (rresp == 2'b10));
endmodule

// File: rtl/axil_err_slave.sv
module axil_err_slave #(
  parameter int unsigned AXI_ADDR_W = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REG_ADDR_W = 8,
  parameter int unsigned NUM_REGS   = 8,
  parameter logic [NUM_REGS-1:0] RD_OK = 8'b0111_1111,
  parameter logic [NUM_REGS-1:0] WR_OK = 8'b1011_1111,
  parameter int unsigned TIMEOUT    = 16,
  localparam int unsigned STRB_W    = DATA_W / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  awvalid,
  output logic                  awready,
  input  logic [AXI_ADDR_W-1:0] awaddr,
  input  logic                  wvalid,
  output logic                  wready,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [STRB_W-1:0]     wstrb,
  output logic                  bvalid,
  input  logic                  bready,
  output logic [1:0]            bresp,
  input  logic                  arvalid,
  output logic                  arready,
  input  logic [AXI_ADDR_W-1:0] araddr,
  output logic                  rvalid,
  input  logic                  rready,
  output logic [DATA_W-1:0]     rdata,
  output logic [1:0]            rresp,
  output logic                  lb_wreq,
  input  logic                  lb_wready,
  output logic [REG_ADDR_W-1:0] lb_waddr,
  output logic [DATA_W-1:0]     lb_wdata,
  output logic [STRB_W-1:0]     lb_wstrb,
  output logic                  lb_rreq,
  input  logic                  lb_rvalid,
  output logic [REG_ADDR_W-1:0] lb_raddr,
  input  logic [DATA_W-1:0]     lb_rdata
);
  axil_err_wr #(
    .AXI_ADDR_W(AXI_ADDR_W), .DATA_W(DATA_W), .REG_ADDR_W(REG_ADDR_W),
    .NUM_REGS(NUM_REGS), .WR_OK(WR_OK), .TIMEOUT(TIMEOUT)
  ) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .lb_wreq(lb_wreq), .lb_wready(lb_wready), .lb_waddr(lb_waddr),
    .lb_wdata(lb_wdata), .lb_wstrb(lb_wstrb)
  );

  axil_err_rd #(
    .AXI_ADDR_W(AXI_ADDR_W), .DATA_W(DATA_W), .REG_ADDR_W(REG_ADDR_W),
    .NUM_REGS(NUM_REGS), .RD_OK(RD_OK), .TIMEOUT(TIMEOUT)
  ) u_rd (
    .clk(clk), .rst_n(rst_n),
    .arvalid(arvalid), .arready(arready), .araddr(araddr),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
    .lb_rreq(lb_rreq), .lb_rvalid(lb_rvalid), .lb_raddr(lb_raddr),
    .lb_rdata(lb_rdata)
  );
endmodule

// File: tb/tb_axil_err_slave.sv
`timescale 1ns/1ps
module tb_axil_err_slave;
  localparam int NREGS = 8;
  localparam int TMO   = 16;
  localparam logic [NREGS-1:0] RDM = 8'b0111_1111;
  localparam logic [NREGS-1:0] WRM = 8'b1011_1111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] awaddr = '0, araddr = '0, wdata = '0;
  logic [3:0]  wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic lb_wreq, lb_rreq;
  logic lb_wready = 0, lb_rvalid = 0;
  logic [7:0] lb_waddr, lb_raddr;
  logic [31:0] lb_wdata, lb_rdata = '0;
  logic [3:0] lb_wstrb;

  axil_err_slave #(.AXI_ADDR_W(32), .DATA_W(32), .REG_ADDR_W(8), .NUM_REGS(NREGS),
                   .RD_OK(RDM), .WR_OK(WRM), .TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .araddr(araddr),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
    .lb_wreq(lb_wreq), .lb_wready(lb_wready), .lb_waddr(lb_waddr),
    .lb_wdata(lb_wdata), .lb_wstrb(lb_wstrb),
    .lb_rreq(lb_rreq), .lb_rvalid(lb_rvalid), .lb_raddr(lb_raddr), .lb_rdata(lb_rdata)
  );

  int n_checks = 0, n_fail = 0;
  int wdelay = 0, rdelay = 0;
  int wreq_cycles = 0, rreq_cycles = 0, lw_count = 0, lr_count = 0;
  logic [7:0]  lw_addr = '0;
  logic [31:0] lw_data = '0;
  logic [3:0]  lw_strb = '0;

  function automatic logic [31:0] rd_model(input logic [7:0] la);
    return {16'hC0DE, la ^ 8'h5A, la};
  endfunction

  function automatic logic [1:0] exp_resp(input bit wr, input int idx, input int dly);
    if (idx >= NREGS) return 2'b11;
    if (wr ? !WRM[idx] : !RDM[idx]) return 2'b10;
    if (dly >= TMO) return 2'b10;
    return 2'b00;
  endfunction

  function automatic int exp_cycles(input bit wr, input int idx, input int dly);
    if (idx >= NREGS) return 0;
    if (wr ? !WRM[idx] : !RDM[idx]) return 0;
    if (dly >= TMO) return TMO;
    return dly + 1;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Local write backend: answers after wdelay request cycles.
  initial begin
    int seen = 0;
    forever begin
      @(negedge clk);
      if (lb_wreq) begin
        wreq_cycles++;
        if (seen == wdelay) begin
          lb_wready = 1'b1;
          lw_count++;
          lw_addr = lb_waddr; lw_data = lb_wdata; lw_strb = lb_wstrb;
        end else lb_wready = 1'b0;
        seen++;
      end else begin
        lb_wready = 1'b0;
        seen = 0;
      end
    end
  end

  // Local read backend.
  initial begin
    int seen = 0;
    forever begin
      @(negedge clk);
      if (lb_rreq) begin
        rreq_cycles++;
        if (seen == rdelay) begin
          lb_rvalid = 1'b1;
          lb_rdata = rd_model(lb_raddr);
          lr_count++;
        end else lb_rvalid = 1'b0;
        seen++;
      end else begin
        lb_rvalid = 1'b0;
        seen = 0;
      end
    end
  end

  task automatic send_aw(input logic [31:0] a);
    @(negedge clk);
    awaddr = a; awvalid = 1'b1;
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 1'b0;
  endtask

  task automatic send_w(input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    wdata = d; wstrb = s; wvalid = 1'b1;
    while (!wready) @(negedge clk);
    @(negedge clk);
    wvalid = 1'b0;
  endtask

  task automatic axi_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                           input int order, input int hold, output logic [1:0] resp);
    bit held_ok = 1;
    case (order)
      0: fork send_aw(a); send_w(d, s); join
      1: begin send_aw(a); repeat (2) @(negedge clk); send_w(d, s); end
      default: begin send_w(d, s); repeat (2) @(negedge clk); send_aw(a); end
    endcase
    while (!bvalid) @(negedge clk);
    resp = bresp;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (!bvalid || bresp !== resp || awready || wready) held_ok = 0;
    end
    check(held_ok, "R9 bvalid hold", {63'd0, held_ok}, 64'd1);
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
  endtask

  task automatic axi_read(input logic [31:0] a, input int hold,
                          output logic [1:0] resp, output logic [31:0] data);
    bit held_ok = 1;
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 1'b0;
    while (!rvalid) @(negedge clk);
    resp = rresp; data = rdata;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (!rvalid || rresp !== resp || rdata !== data || arready) held_ok = 0;
    end
    check(held_ok, "R9 rvalid hold", {63'd0, held_ok}, 64'd1);
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
  endtask

  task automatic do_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                       input int order, input int dly, input int hold, input string tag);
    logic [1:0] resp;
    int idx = int'(a[7:2]);
    int w0 = wreq_cycles, c0 = lw_count;
    logic [1:0] er = exp_resp(1, idx, dly);
    wdelay = dly;
    axi_write(a, d, s, order, hold, resp);
    check(resp === er, tag, {62'd0, resp}, {62'd0, er});
    check(wreq_cycles - w0 == exp_cycles(1, idx, dly), tag,
          64'(wreq_cycles - w0), 64'(exp_cycles(1, idx, dly)));
    if (er == 2'b00) begin
      check(lw_count == c0 + 1, "R2 one local write", 64'(lw_count - c0), 64'd1);
      check(lw_addr == {a[7:2], 2'b00} && lw_data == d && lw_strb == s, "R2 R8 local write payload",
            {lw_addr, lw_strb, lw_data}, {a[7:2], 2'b00, s, d});
    end else
      check(lw_count == c0, "R5 R6 R7 no local write", 64'(lw_count - c0), 64'd0);
  endtask

  task automatic do_rd(input logic [31:0] a, input int dly, input int hold, input string tag);
    logic [1:0] resp;
    logic [31:0] data;
    int idx = int'(a[7:2]);
    int r0 = rreq_cycles;
    logic [1:0] er = exp_resp(0, idx, dly);
    logic [31:0] ed = (er == 2'b00) ? rd_model({a[7:2], 2'b00}) : 32'd0;
    rdelay = dly;
    axi_read(a, hold, resp, data);
    check(resp === er, tag, {62'd0, resp}, {62'd0, er});
    check(data === ed, tag, {32'd0, data}, {32'd0, ed});
    check(rreq_cycles - r0 == exp_cycles(0, idx, dly), tag,
          64'(rreq_cycles - r0), 64'(exp_cycles(0, idx, dly)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(awready && wready && arready && !bvalid && !rvalid && !lb_wreq && !lb_rreq, "R1 reset state",
          {57'd0, awready, wready, arready, bvalid, rvalid, lb_wreq, lb_rreq}, 64'b1110000);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: each arrival order, strobes passed through
    do_wr(32'h0000_0004, 32'h1111_2222, 4'b1111, 0, 0, 0, "R2 together");
    do_wr(32'h0000_0008, 32'h3333_4444, 4'b0101, 1, 2, 1, "R2 aw first");
    do_wr(32'h0000_000C, 32'h5555_6666, 4'b1000, 2, 1, 0, "R2 w first");
    // R3 R4: normal completion with latency
    do_wr(32'h0000_0000, 32'hDEAD_BEEF, 4'b0011, 0, 5, 0, "R3 latency write");
    do_rd(32'h0000_0010, 3, 0, "R4 latency read");
    // R8: upper bits ignored
    do_wr(32'hFFFF_FF14, 32'h0BAD_F00D, 4'b1111, 0, 0, 0, "R8 high base write");
    do_rd(32'h8000_0017, 0, 0, "R8 high base read");
    // R5: unmapped
    do_wr(32'h0000_0020, 32'h1, 4'hF, 0, 0, 0, "R5 unmapped write");
    do_rd(32'h0000_00FC, 0, 2, "R5 unmapped read");
    // R6: wrong direction
    do_wr(32'h0000_0018, 32'h2, 4'hF, 1, 0, 0, "R6 write read-only");
    do_rd(32'h0000_001C, 0, 0, "R6 read write-only");
    do_rd(32'h0000_0018, 0, 0, "R6 read read-only ok");
    do_wr(32'h0000_001C, 32'h3, 4'hF, 0, 0, 0, "R6 write write-only ok");
    // R7: timeout boundary
    do_wr(32'h0000_0004, 32'h4, 4'hF, 0, TMO - 1, 0, "R7 write last cycle");
    do_wr(32'h0000_0004, 32'h5, 4'hF, 0, TMO, 0, "R7 write timeout");
    do_rd(32'h0000_0004, TMO - 1, 0, "R7 read last cycle");
    do_rd(32'h0000_0004, TMO, 1, "R7 read timeout");
    do_rd(32'h0000_0004, 1000, 0, "R7 read no answer");
    // R9: long stalls
    do_wr(32'h0000_0008, 32'h6, 4'hF, 2, 0, 5, "R9 write stall");
    do_rd(32'h0000_0008, 0, 5, "R9 read stall");

    for (int n = 0; n < 160; n++) begin
      logic [31:0] a;
      int idx = int'($urandom_range(0, 11));
      int dly = ($urandom_range(0, 7) == 0) ? TMO + int'($urandom_range(0, 3)) : int'($urandom_range(0, TMO - 1));
      a = {$urandom() & 32'hFFFF_FF00} | {24'd0, 6'(idx), 2'($urandom_range(0, 3))};
      if ($urandom_range(0, 1) == 1)
        do_wr(a, $urandom(), 4'($urandom_range(0, 15)), int'($urandom_range(0, 2)), dly,
              int'($urandom_range(0, 3)), "R2 R5 R6 R7 R8 random write");
      else
        do_rd(a, dly, int'($urandom_range(0, 3)), "R4 R5 R6 R7 R8 random read");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule